// File: doc/BRIEF.md
# Input Clock Loss Monitor with Clock-Manager Reset Sequencing

This block decides whether a monitored clock is running, and it does so from a separate reference clock that never stops. A clock manager's lock flag cannot answer that question. The flag only changes on input clock edges, so it stays high after the input clock dies.

The monitored clock drives a toggle flop. The reference domain synchronises the toggle and turns every change into an edge pulse. A timeout counter reloads on each edge. If the counter reaches a programmable limit, the clock is declared lost. The block then drives the upstream clock manager into reset and sets a sticky loss flag that the host clears.

Recovery needs two things. The reset must have been held for a programmable minimum number of reference cycles, and a programmable number of consecutive toggle edges must have been seen. A downstream chained clock manager is kept in reset while the upstream one is in reset. It also stays in reset until the synchronised upstream lock flag is high.

The monitored clock must run at no more than half the reference frequency so that each toggle level is sampled at least once.

Top module: `clk_loss_guard`

## Requirements
- R1: While rst_ni is low: up_rst_o=1, dn_rst_o=1, clk_present_o=0 and lost_sticky_o=0.
- R2: clk_present_o is 1 exactly while the block is in the running state. It returns to 1 after every completed recovery.
- R3: Loss detection works as follows, whatever the value of up_locked_i:
  - When timeout_i reference cycles pass with no detected toggle edge, the block leaves the running state. On the next cycle clk_present_o=0 and up_rst_o=1.
  - A gap that stays well below timeout_i causes no loss.
- R4: Once asserted, up_rst_o stays high for at least min_rst_i reference cycles.
- R5: up_rst_o is released only under all of these conditions:
  - the minimum hold of R4 has elapsed;
  - relock_edges_i toggle edges have been detected with no timeout between them;
  - the timeout condition is not active.
  A timeout during recovery restarts the edge count. With the monitored clock stopped, the block is never released.
- R6: lost_sticky_o sets on every transition from running to lost. The first bring-up after reset does not set it. It holds until a cycle with lost_clr_i=1 clears it, and a new loss in that same cycle wins over the clear.
- R7: dn_rst_o is 1 in every cycle in which up_rst_o is 1, and also while the two-flop-synchronised up_locked_i is 0. It falls only once both conditions are gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Always-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mon_clk_i | input | 1 | Monitored clock |
| up_locked_i | input | 1 | Lock flag of the upstream clock manager (asynchronous) |
| timeout_i | input | CNT_W | Reference cycles without an edge before loss is declared |
| min_rst_i | input | CNT_W | Minimum reset hold in reference cycles |
| relock_edges_i | input | EDGE_W | Consecutive edges needed to release reset |
| lost_clr_i | input | 1 | Host clear of the sticky loss flag |
| clk_present_o | output | 1 | Monitored clock judged present |
| up_rst_o | output | 1 | Reset to the upstream clock manager |
| dn_rst_o | output | 1 | Reset to the downstream chained clock manager |
| lost_sticky_o | output | 1 | Sticky loss indication |

## Verification
The hardest case to reach is a recovery that is interrupted: the clock returns, produces fewer edges than the release needs, then stops again for longer than the timeout. The bench gets there in three steps:
- it counts monitored clock edges itself and stops the generator after a chosen number;
- it waits through a gap longer than the limit;
- it restarts the clock and checks that the release comes only after a fresh full run of edges.

Randomised stop gaps fall either clearly below or clearly above the limit, so the bench knows whether a loss is expected. The clock-manager model keeps its lock flag high after its clock stops, which recreates the frozen-lock situation at the ports.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic [0:0] {
    ST_RECOVER = 1'b0,
    ST_RUN     = 1'b1
  } mon_state_e;
endpackage

// File: rtl/clkmon_toggle.sv
module clkmon_toggle (
  input  logic mon_clk_i,
  input  logic rst_ni,
  output logic tog_o
);
  always_ff @(posedge mon_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_o <= 1'b0;
    else         tog_o <= ~tog_o;
  end
endmodule

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[0] <= RST_VAL;
        else         ff_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= RST_VAL;
        else         ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/clkmon_timeout.sv
module clkmon_timeout #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tog_s_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             edge_o,
  output logic             expired_o
);
  logic             tog_d_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_d_q <= 1'b0;
    else         tog_d_q <= tog_s_i;
  end

  assign edge_o = tog_s_i ^ tog_d_q;

  // saturating silence counter, reloaded by each edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (edge_o)          cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i) && !edge_o;
endmodule

// File: rtl/clkmon_rst_seq.sv
module clkmon_rst_seq
  import clkmon_pkg::*;
#(
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned EDGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              expired_i,
  input  logic [CNT_W-1:0]  min_rst_i,
  input  logic [EDGE_W-1:0] relock_edges_i,
  input  logic              lost_clr_i,
  output logic              up_rst_o,
  output logic              up_rst_d_o,
  output logic              clk_present_o,
  output logic              lost_sticky_o
);
  mon_state_e        state_q, state_d;
  logic [CNT_W-1:0]  hold_q, hold_d;
  logic [EDGE_W-1:0] edges_q, edges_d;
  logic              loss_evt;
  logic              release_ok;

  assign release_ok = (hold_q >= min_rst_i) && (edges_q >= relock_edges_i) && !expired_i;

  always_comb begin
    state_d  = state_q;
    loss_evt = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (expired_i) begin
          state_d  = ST_RECOVER;
          loss_evt = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (release_ok) state_d = ST_RUN;
      end
      default: state_d = ST_RECOVER;
    endcase
  end

  always_comb begin
    if (state_q == ST_RUN)  hold_d = '0;
    else if (hold_q != '1)  hold_d = hold_q + 1'b1;
    else                    hold_d = hold_q;
  end

  // consecutive edges: any timeout during recovery restarts the run
  always_comb begin
    if (state_q == ST_RUN || expired_i) edges_d = '0;
    else if (edge_i && edges_q != '1)   edges_d = edges_q + 1'b1;
    else                                edges_d = edges_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RECOVER;
      hold_q  <= '0;
      edges_q <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      edges_q <= edges_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lost_sticky_o <= 1'b0;
    else if (loss_evt)   lost_sticky_o <= 1'b1;
    else if (lost_clr_i) lost_sticky_o <= 1'b0;
  end

  assign up_rst_o      = (state_q == ST_RECOVER);
  assign up_rst_d_o    = (state_d == ST_RECOVER);
  assign clk_present_o = (state_q == ST_RUN);
endmodule

// File: rtl/clk_loss_guard.sv
module clk_loss_guard #(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned EDGE_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic              mon_clk_i,
  input  logic              up_locked_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic [CNT_W-1:0]  min_rst_i,
  input  logic [EDGE_W-1:0] relock_edges_i,
  input  logic              lost_clr_i,
  output logic              clk_present_o,
  output logic              up_rst_o,
  output logic              dn_rst_o,
  output logic              lost_sticky_o
);
  logic tog;
  logic tog_s;
  logic lock_s;
  logic tog_edge;
  logic expired;
  logic up_rst_d;
  logic dn_rst_q;

  clkmon_toggle u_toggle (
    .mon_clk_i (mon_clk_i),
    .rst_ni    (rst_ni),
    .tog_o     (tog)
  );

  clkmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    (tog),
    .q_o    (tog_s)
  );

  clkmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    (up_locked_i),
    .q_o    (lock_s)
  );

  clkmon_timeout #(.CNT_W(CNT_W)) u_timeout (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .tog_s_i   (tog_s),
    .limit_i   (timeout_i),
    .edge_o    (tog_edge),
    .expired_o (expired)
  );

  clkmon_rst_seq #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) u_seq (
    .clk_i          (ref_clk_i),
    .rst_ni         (rst_ni),
    .edge_i         (tog_edge),
    .expired_i      (expired),
    .min_rst_i      (min_rst_i),
    .relock_edges_i (relock_edges_i),
    .lost_clr_i     (lost_clr_i),
    .up_rst_o       (up_rst_o),
    .up_rst_d_o     (up_rst_d),
    .clk_present_o  (clk_present_o),
    .lost_sticky_o  (lost_sticky_o)
  );

  // downstream held while upstream is in reset or not yet locked
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) dn_rst_q <= 1'b1;
    else         dn_rst_q <= up_rst_d | ~lock_s;
  end

  assign dn_rst_o = dn_rst_q;
endmodule

// File: rtl/clk_loss_guard_checker.sv
module clk_loss_guard_checker #(
  parameter int unsigned CNT_W = 12
) (
  input logic             ref_clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] min_rst_i,
  input logic             lost_clr_i,
  input logic             clk_present_o,
  input logic             up_rst_o,
  input logic             dn_rst_o,
  input logic             lost_sticky_o,
  input logic             expired_i
);
  logic [CNT_W:0] run_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)                   run_q <= '0;
    else if (!up_rst_o)            run_q <= '0;
    else if (run_q != '1)          run_q <= run_q + 1'b1;
  end

  assert_loss_on_expiry_R3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (clk_present_o && expired_i) |=> (up_rst_o && !clk_present_o));

  assert_min_hold_R4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(up_rst_o) |-> (run_q >= {1'b0, min_rst_i}));

  assert_release_clean_R5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(up_rst_o) |-> !$past(expired_i));

  assert_sticky_on_loss_R6: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(clk_present_o) |-> lost_sticky_o);

  assert_sticky_clear_R6: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (lost_clr_i && !(clk_present_o && expired_i)) |=> !lost_sticky_o);

  assert_dn_covers_up_R7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    up_rst_o |-> dn_rst_o);
endmodule

bind clk_loss_guard clk_loss_guard_checker #(.CNT_W(CNT_W)) u_chk (
  .ref_clk_i     (ref_clk_i),
  .rst_ni        (rst_ni),
  .min_rst_i     (min_rst_i),
  .lost_clr_i    (lost_clr_i),
  .clk_present_o (clk_present_o),
  .up_rst_o      (up_rst_o),
  .dn_rst_o      (dn_rst_o),
  .lost_sticky_o (lost_sticky_o),
  .expired_i     (expired)
);

// File: tb/tb_clk_loss_guard.sv
`timescale 1ns/1ps
module tb_clk_loss_guard;
  localparam int CNT_W  = 12;
  localparam int EDGE_W = 5;
  localparam int TMO    = 24;

  logic ref_clk = 1'b0;
  logic mon_clk = 1'b0;
  logic rst_ni  = 1'b0;
  logic up_locked;
  logic [CNT_W-1:0]  timeout;
  logic [CNT_W-1:0]  min_rst;
  logic [EDGE_W-1:0] relock;
  logic lost_clr;
  logic present, up_rst, dn_rst, sticky;

  real mon_half = 5.3;
  bit  mon_run  = 1'b0;
  int  mon_edges = 0;
  int  lock_cnt;
  int  checks = 0;
  int  errors = 0;
  int  dn_viol = 0;
  bit  done = 1'b0;

  always #2 ref_clk = ~ref_clk;

  always begin
    if (mon_run) begin
      #(mon_half);
      mon_clk = ~mon_clk;
    end else begin
      #1;
    end
  end

  always @(posedge mon_clk) mon_edges++;

  // clock manager model: lock needs clock edges, so it freezes when the clock stops
  always @(posedge mon_clk or posedge up_rst) begin
    if (up_rst) begin
      lock_cnt  <= 0;
      up_locked <= 1'b0;
    end else if (lock_cnt < 5) begin
      lock_cnt <= lock_cnt + 1;
    end else begin
      up_locked <= 1'b1;
    end
  end

  always @(negedge ref_clk) if (rst_ni && up_rst && !dn_rst) dn_viol++;

  clk_loss_guard #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) dut (
    .ref_clk_i      (ref_clk),
    .rst_ni         (rst_ni),
    .mon_clk_i      (mon_clk),
    .up_locked_i    (up_locked),
    .timeout_i      (timeout),
    .min_rst_i      (min_rst),
    .relock_edges_i (relock),
    .lost_clr_i     (lost_clr),
    .clk_present_o  (present),
    .up_rst_o       (up_rst),
    .dn_rst_o       (dn_rst),
    .lost_sticky_o  (sticky)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wait_rst(input logic want, input int lim, output int n);
    n = 0;
    while (up_rst !== want && n < lim) begin
      @(negedge ref_clk);
      n++;
    end
  endtask

  task automatic clear_sticky();
    lost_clr = 1'b1;
    cyc(1);
    lost_clr = 1'b0;
  endtask

  function automatic bit in_range(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic int exp_release_edges(input int need);
    return need;
  endfunction

  initial begin
    int n, base, d, k;
    timeout  = TMO;
    min_rst  = 10;
    relock   = 4;
    lost_clr = 1'b0;
    void'($urandom(32'd4242));

    // R1 reset state
    cyc(5);
    chk(up_rst == 1'b1,  "R1", "up_rst in reset", up_rst, 1);
    chk(dn_rst == 1'b1,  "R1", "dn_rst in reset", dn_rst, 1);
    chk(present == 1'b0, "R1", "present in reset", present, 0);
    chk(sticky == 1'b0,  "R1", "sticky in reset", sticky, 0);
    rst_ni = 1'b1;

    // R5 no release without a clock
    cyc(60);
    chk(up_rst == 1'b1, "R5", "held with clock absent", up_rst, 1);

    // bring-up
    base = mon_edges;
    mon_run = 1'b1;
    wait_rst(1'b0, 400, n);
    d = mon_edges - base;
    chk(up_rst == 1'b0, "R5", "released after bring-up", up_rst, 0);
    chk(d >= exp_release_edges(4), "R5", "edges before bring-up release", d, 4);
    chk(present == 1'b1, "R2", "present after bring-up", present, 1);
    chk(sticky == 1'b0,  "R6", "bring-up sets no sticky", sticky, 0);
    chk(dn_rst == 1'b1,  "R7", "dn_rst before lock", dn_rst, 1);
    k = 0;
    while (!up_locked && k < 200) begin cyc(1); k++; end
    cyc(4);
    chk(dn_rst == 1'b0, "R7", "dn_rst released after lock", dn_rst, 0);

    // R3 loss with frozen lock flag, R4 long minimum hold
    min_rst = 40;
    cyc(20);
    mon_run = 1'b0;
    cyc(18);
    chk(present == 1'b1, "R3", "no loss before limit", present, 1);
    chk(up_locked == 1'b1, "R3", "lock flag frozen high", up_locked, 1);
    wait_rst(1'b1, 20, n);
    chk(in_range(18 + n, 19, 34), "R3", "loss latency cycles", 18 + n, TMO);
    chk(present == 1'b0, "R3", "present dropped", present, 0);
    chk(sticky == 1'b1,  "R6", "sticky set on loss", sticky, 1);
    chk(dn_rst == 1'b1,  "R7", "dn_rst with up_rst", dn_rst, 1);
    mon_run = 1'b1;
    wait_rst(1'b0, 200, n);
    chk(in_range(n, 40, 48), "R4", "reset hold length", n, 41);
    chk(present == 1'b1, "R2", "present after recovery", present, 1);
    cyc(10);
    chk(sticky == 1'b1, "R6", "sticky holds after recovery", sticky, 1);
    clear_sticky();
    cyc(1);
    chk(sticky == 1'b0, "R6", "sticky cleared", sticky, 0);

    // R5 edge count with a slow clock
    min_rst  = 1;
    relock   = 6;
    mon_half = 16.3;
    cyc(40);
    mon_run = 1'b0;
    wait_rst(1'b1, 60, n);
    cyc(20);
    base = mon_edges;
    mon_run = 1'b1;
    wait_rst(1'b0, 400, n);
    d = mon_edges - base;
    chk(in_range(d, 6, 7), "R5", "edges before release", d, 6);

    // R5 interrupted recovery restarts the count
    cyc(30);
    mon_run = 1'b0;
    wait_rst(1'b1, 60, n);
    cyc(10);
    base = mon_edges;
    mon_run = 1'b1;
    k = 0;
    while (mon_edges - base < 3 && k < 200) begin cyc(1); k++; end
    mon_run = 1'b0;
    cyc(45);
    chk(up_rst == 1'b1, "R5", "held through interrupted recovery", up_rst, 1);
    base = mon_edges;
    mon_run = 1'b1;
    wait_rst(1'b0, 400, n);
    d = mon_edges - base;
    chk(in_range(d, 6, 7), "R5", "fresh edges after interruption", d, 6);
    clear_sticky();

    // R3 random gaps, long or short
    relock = 2;
    for (int it = 0; it < 24; it++) begin
      bit long_gap;
      int gap;
      mon_half = 4.3 + 0.7 * real'($urandom_range(0, 2));
      cyc(30);
      clear_sticky();
      long_gap = 1'($urandom_range(0, 1));
      gap = long_gap ? TMO + 10 + int'($urandom_range(0, 20)) : int'($urandom_range(2, TMO - 10));
      mon_run = 1'b0;
      cyc(gap);
      mon_run = 1'b1;
      cyc(60);
      chk(sticky == long_gap, "R3", "loss iff long gap", sticky, long_gap);
      chk(present == 1'b1, "R2", "present after gap", present, 1);
    end

    chk(dn_viol == 0, "R7", "dn_rst low while up_rst high", dn_viol, 0);

    // R1 reset while running
    rst_ni = 1'b0;
    cyc(2);
    chk(up_rst == 1'b1 && present == 1'b0 && sticky == 1'b0, "R1", "mid-run reset",
        {up_rst, present, sticky}, 3'b100);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge ref_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule